// File: doc/BRIEF.md
# Partial-Word Store Byte Aligner

This block converts a "store a leading or trailing run of bytes" request into exactly one write beat on a big-endian memory bus. A request carries a byte address, a store value, a span-mode bit and a unit-size bit. The unit is either a word of four bytes or a doubleword of eight bytes.

In from-address mode, the bytes from the addressed byte up to the last byte of the aligned unit are written. In below-address mode, the bytes from the first byte of the unit up to, but not including, the addressed byte are written. The store value is laid over the unit so that its least significant byte sits at the unit's last address. The byte enables then pick the run.

Because every request leaves as a single masked beat, a 3-, 5-, 6- or 7-byte store can never be seen half done. One case writes nothing: below-address mode with a unit offset of zero. That case still issues a beat with all enables low, and raises a separate flag so that the memory side can run a protection probe on the line. The result is registered with one cycle of latency behind a valid/ready handshake.

Top module: `pstore_aligner`

## Requirements
- R1: `bus_addr` equals the request address with its low 2 bits cleared for a word unit (`req_dword`=0) and its low 3 bits cleared for a doubleword unit (`req_dword`=1).
- R2: Word unit in from-address mode (`req_span_end`=0) with unit offset k = addr[1:0]: within the selected word, bytes k to 3 are enabled, and they carry the low 4−k bytes of `req_data[31:0]`. For example, offset 1 gives the in-word mask 0x00FFFFFF and offset 0 gives a full 4-byte write. Bits 63:32 of `req_data` have no effect.
- R3: Word unit in below-address mode (`req_span_end`=1) with offset k = 1, 2 or 3: word bytes 0 to k−1 are enabled, and they carry the top k bytes of `req_data[31:0]`. Offset 3 gives the in-word mask 0xFFFFFF00.
- R4: Doubleword unit in from-address mode with offset k = addr[2:0]: lanes k to 7 are enabled, and they carry the low 8−k bytes of `req_data`. Offset 0 writes all 8 bytes.
- R5: Doubleword unit in below-address mode with offset k: lanes 0 to k−1 are enabled, and they carry the k most significant bytes of `req_data`. For example, offset 5 gives the mask 0xFFFFFFFFFF000000.
- R6: Below-address mode with a unit offset of 0 still produces one beat, with `bus_be` = 0 and `bus_empty` = 1. Every other request gives `bus_empty` = 0.
- R7: The lane order is big-endian. `bus_be[i]` enables lane i, which is `bus_wdata[63-8i -: 8]`, and lane 0 is the lowest address in the doubleword. A word with addr[2]=0 uses lanes 0 to 3, and a word with addr[2]=1 uses lanes 4 to 7. The enabled lanes always form one contiguous run.
- R8: Each accepted request produces exactly one bus beat, and no beat appears without an accepted request.
- R9: A request accepted at a clock edge is presented on the bus outputs, with `bus_valid` high, after that edge.
- R10: While `bus_valid` is high and `bus_ready` is low, the bus outputs hold still and `req_ready` is low. With `bus_valid` low, `req_ready` is high.
- R11: During and directly after reset, `bus_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 8*LANES | Store value; word units use the low 32 bits |
| req_span_end | input | 1 | 0: from address to unit end; 1: unit start to below address |
| req_dword | input | 1 | 0: word unit; 1: doubleword unit |
| bus_valid | output | 1 | Beat present |
| bus_ready | input | 1 | Bus takes the beat |
| bus_addr | output | ADDR_W | Aligned address |
| bus_be | output | LANES | Per-lane byte enables, bit 0 = most significant lane |
| bus_wdata | output | 8*LANES | Lane-positioned write data |
| bus_empty | output | 1 | Beat writes no byte (probe only) |

## Verification
On every cycle the assertions check four things at the ports. Stalled beats must stay frozen. An accepted request must turn into a beat on the next cycle, and no beat may appear from nothing. The address must be aligned to at least a word. The empty flag must agree with an all-zero enable mask, and every non-empty mask must be a single contiguous lane run. Only the bench's scenarios can show that the run starts and ends at the right lane for each mode, size and offset, and that the right value bytes land in those lanes. They also show that the upper value half is ignored for words, that a word picks the correct half of the bus, and that exactly one beat leaves per request under backpressure.

// File: rtl/pstore_pkg.sv
package pstore_pkg;

   // span selection: write from the addressed byte to the unit end,
   // or from the unit start up to the byte below the address
   typedef enum logic {
      SPAN_FROM_ADDR  = 1'b0,
      SPAN_BELOW_ADDR = 1'b1
   } span_e;

   // access unit: half of the bus or the full bus
   typedef enum logic {
      UNIT_WORD  = 1'b0,
      UNIT_DWORD = 1'b1
   } unit_e;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pstore_span_mask.sv
module pstore_span_mask
   import pstore_pkg::*;
#(
   parameter int LANES      = 8,
   parameter int WORD_BYTES = 4
) (
   input  logic [$clog2(LANES)-1:0] ofs,
   input  span_e                    span,
   input  unit_e                    unit,
   output logic [LANES-1:0]         lane_en,
   output logic                     nothing
);

   localparam int LANE_LOG = $clog2(LANES);
   localparam int WORD_LOG = $clog2(WORD_BYTES);
   localparam int SEL_W    = LANE_LOG - WORD_LOG;

   logic [WORD_LOG-1:0] ofs_w;
   logic [SEL_W-1:0]    word_sel;
   logic                below;

   assign ofs_w    = ofs[WORD_LOG-1:0];
   assign word_sel = ofs[LANE_LOG-1:WORD_LOG];
   assign below    = (span == SPAN_BELOW_ADDR);

   // one comparator pair per lane; the lane's position inside the
   // doubleword and inside its word are constants of the loop
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [LANE_LOG-1:0] POS_D = LANE_LOG'(i);
      localparam logic [WORD_LOG-1:0] POS_W = WORD_LOG'(i % WORD_BYTES);
      localparam logic [SEL_W-1:0]    SEL   = SEL_W'(i / WORD_BYTES);

      logic hit_d;
      logic hit_w;

      always_comb begin
         if (below) begin
            hit_d = (POS_D < ofs);
            hit_w = (word_sel == SEL) && (POS_W < ofs_w);
         end else begin
            hit_d = (POS_D >= ofs);
            hit_w = (word_sel == SEL) && (POS_W >= ofs_w);
         end
      end

      assign lane_en[i] = (unit == UNIT_DWORD) ? hit_d : hit_w;
   end

   // an empty beat only arises below an offset of zero
   always_comb begin
      if (unit == UNIT_DWORD) nothing = below && (ofs == '0);
      else                    nothing = below && (ofs_w == '0);
   end

endmodule

// File: rtl/pstore_lane_map.sv
module pstore_lane_map
   import pstore_pkg::*;
#(
   parameter int LANES      = 8,
   parameter int WORD_BYTES = 4,
   parameter bit MSB_LANE0  = 1'b1
) (
   input  logic [8*LANES-1:0] value,
   input  unit_e              unit,
   output logic [8*LANES-1:0] wdata
);

   // Lane i is address i inside the doubleword.  The value byte that a
   // big-endian memory keeps at that address is fixed per lane: for a
   // doubleword it is byte LANES-1-i of the value, for a word it is
   // byte WORD_BYTES-1-(i mod WORD_BYTES), so the word value appears in
   // both halves of the bus and the enables pick the half.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int SRC_D = LANES - 1 - i;
      localparam int SRC_W = WORD_BYTES - 1 - (i % WORD_BYTES);

      logic [7:0] lane_byte;

      assign lane_byte = (unit == UNIT_DWORD) ? value[8*SRC_D +: 8]
                                              : value[8*SRC_W +: 8];

      if (MSB_LANE0) begin : g_msb_first
         assign wdata[8*(LANES-1-i) +: 8] = lane_byte;
      end else begin : g_lsb_first
         assign wdata[8*i +: 8] = lane_byte;
      end
   end

endmodule

// File: rtl/pstore_beat_reg.sv
module pstore_beat_reg #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic [LANES-1:0]    in_be,
   input  logic [8*LANES-1:0]  in_wdata,
   input  logic                in_empty,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [ADDR_W-1:0]   out_addr,
   output logic [LANES-1:0]    out_be,
   output logic [8*LANES-1:0]  out_wdata,
   output logic                out_empty
);

   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (in_ready) begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_addr  <= '0;
         out_be    <= '0;
         out_wdata <= '0;
         out_empty <= 1'b0;
      end else if (take) begin
         out_addr  <= in_addr;
         out_be    <= in_be;
         out_wdata <= in_wdata;
         out_empty <= in_empty;
      end
   end

endmodule

// File: rtl/pstore_aligner.sv
module pstore_aligner
   import pstore_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LANES      = 8,
   parameter int WORD_BYTES = 4,
   parameter bit MSB_LANE0  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [8*LANES-1:0]  req_data,
   input  logic                req_span_end,
   input  logic                req_dword,
   output logic                bus_valid,
   input  logic                bus_ready,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [LANES-1:0]    bus_be,
   output logic [8*LANES-1:0]  bus_wdata,
   output logic                bus_empty
);

   localparam int LANE_LOG = $clog2(LANES);
   localparam int WORD_LOG = $clog2(WORD_BYTES);

   // elaboration-time parameter checks
   if (!is_pow2(LANES)) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end
   if (!is_pow2(WORD_BYTES) || WORD_BYTES < 2) begin : g_bad_word
      $error("WORD_BYTES must be a power of two of at least 2");
   end
   if (LANES < 2 * WORD_BYTES) begin : g_bad_ratio
      $error("LANES must hold at least two words");
   end
   if (ADDR_W <= LANE_LOG) begin : g_bad_addr
      $error("ADDR_W too narrow for the lane count");
   end

   span_e                span;
   unit_e                unit;
   logic [LANES-1:0]     lane_en;
   logic                 nothing;
   logic [8*LANES-1:0]   lane_data;
   logic [ADDR_W-1:0]    base_addr;

   assign span = span_e'(req_span_end);
   assign unit = unit_e'(req_dword);

   always_comb begin
      base_addr = req_addr;
      if (unit == UNIT_DWORD) base_addr[LANE_LOG-1:0] = '0;
      else                    base_addr[WORD_LOG-1:0] = '0;
   end

   pstore_span_mask #(
      .LANES      (LANES),
      .WORD_BYTES (WORD_BYTES)
   ) i_mask (
      .ofs     (req_addr[LANE_LOG-1:0]),
      .span    (span),
      .unit    (unit),
      .lane_en (lane_en),
      .nothing (nothing)
   );

   pstore_lane_map #(
      .LANES      (LANES),
      .WORD_BYTES (WORD_BYTES),
      .MSB_LANE0  (MSB_LANE0)
   ) i_map (
      .value (req_data),
      .unit  (unit),
      .wdata (lane_data)
   );

   pstore_beat_reg #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES)
   ) i_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .in_addr   (base_addr),
      .in_be     (lane_en),
      .in_wdata  (lane_data),
      .in_empty  (nothing),
      .out_valid (bus_valid),
      .out_ready (bus_ready),
      .out_addr  (bus_addr),
      .out_be    (bus_be),
      .out_wdata (bus_wdata),
      .out_empty (bus_empty)
   );

endmodule

// File: rtl/pstore_aligner_chk.sv
module pstore_aligner_chk #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [8*LANES-1:0]  req_data,
   input logic                req_span_end,
   input logic                req_dword,
   input logic                bus_valid,
   input logic                bus_ready,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [LANES-1:0]    bus_be,
   input logic [8*LANES-1:0]  bus_wdata,
   input logic                bus_empty
);

   // edges of the enable run: a single contiguous run has two
   logic [LANES+1:0] be_ext;
   assign be_ext = {1'b0, bus_be, 1'b0};

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
         $stable(bus_be) && $stable(bus_wdata) && $stable(bus_empty)));

   // R10
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> req_ready);

   // R9
   accept_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> bus_valid);

   // R8
   no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid && !req_valid) |=> !bus_valid);

   // R1
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_addr[1:0] == 2'b00));

   // R6
   empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_empty == (bus_be == '0)));

   // R7
   run_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_empty) |->
         ($countones(be_ext[LANES+1:1] ^ be_ext[LANES:0]) == 2));

endmodule

bind pstore_aligner pstore_aligner_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES)
) i_chk (.*);

// File: tb/test_pstore_aligner.sv
module test_pstore_aligner;

   typedef struct packed {
      logic [31:0] addr;
      logic [63:0] val;
      logic        span_end;
      logic        dword;
      logic [31:0] e_addr;
      logic [7:0]  e_be;
      logic [63:0] e_wd;
      logic        e_empty;
   } vec_t;

   localparam logic [63:0] WV = 64'hDEADBEEF_A1B2C3D4;
   localparam logic [63:0] DV = 64'h88112233_44556677;
   localparam int NV = 17;

   localparam vec_t VECS [NV] = '{
      '{32'h100, WV, 1'b0, 1'b0, 32'h100, 8'h0F, 64'hA1B2C3D4_00000000, 1'b0},
      '{32'h105, WV, 1'b0, 1'b0, 32'h104, 8'hE0, 64'h00000000_00B2C3D4, 1'b0},
      '{32'h103, WV, 1'b0, 1'b0, 32'h100, 8'h08, 64'h000000D4_00000000, 1'b0},
      '{32'h106, WV, 1'b0, 1'b0, 32'h104, 8'hC0, 64'h00000000_0000C3D4, 1'b0},
      '{32'h101, WV, 1'b0, 1'b0, 32'h100, 8'h0E, 64'h00B2C3D4_00000000, 1'b0},
      '{32'h107, WV, 1'b1, 1'b0, 32'h104, 8'h70, 64'h00000000_A1B2C300, 1'b0},
      '{32'h102, WV, 1'b1, 1'b0, 32'h100, 8'h03, 64'hA1B20000_00000000, 1'b0},
      '{32'h101, WV, 1'b1, 1'b0, 32'h100, 8'h01, 64'hA1000000_00000000, 1'b0},
      '{32'h104, WV, 1'b1, 1'b0, 32'h104, 8'h00, 64'h0,                 1'b1},
      '{32'h200, DV, 1'b0, 1'b1, 32'h200, 8'hFF, 64'h88112233_44556677, 1'b0},
      '{32'h203, DV, 1'b0, 1'b1, 32'h200, 8'hF8, 64'h00000033_44556677, 1'b0},
      '{32'h207, DV, 1'b0, 1'b1, 32'h200, 8'h80, 64'h00000000_00000077, 1'b0},
      '{32'h205, DV, 1'b1, 1'b1, 32'h200, 8'h1F, 64'h88112233_44000000, 1'b0},
      '{32'h201, DV, 1'b1, 1'b1, 32'h200, 8'h01, 64'h88000000_00000000, 1'b0},
      '{32'h206, DV, 1'b1, 1'b1, 32'h200, 8'h3F, 64'h88112233_44550000, 1'b0},
      '{32'h207, DV, 1'b1, 1'b1, 32'h200, 8'h7F, 64'h88112233_44556600, 1'b0},
      '{32'h208, DV, 1'b1, 1'b1, 32'h208, 8'h00, 64'h0,                 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [63:0] req_data = '0;
   logic        req_span_end = 1'b0;
   logic        req_dword = 1'b0;
   logic        bus_valid;
   logic        bus_ready = 1'b1;
   logic [31:0] bus_addr;
   logic [7:0]  bus_be;
   logic [63:0] bus_wdata;
   logic        bus_empty;

   int total = 0;
   int bad = 0;
   int beats = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pstore_aligner i_pstore_aligner (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_data     (req_data),
      .req_span_end (req_span_end),
      .req_dword    (req_dword),
      .bus_valid    (bus_valid),
      .bus_ready    (bus_ready),
      .bus_addr     (bus_addr),
      .bus_be       (bus_be),
      .bus_wdata    (bus_wdata),
      .bus_empty    (bus_empty)
   );

   always @(posedge clk) begin
      if (rst_n && bus_valid && bus_ready) beats <= beats + 1;
   end

   function automatic logic [63:0] lane_mask(logic [7:0] be);
      logic [63:0] m = '0;
      for (int i = 0; i < 8; i++) begin
         if (be[i]) m[63-8*i -: 8] = 8'hFF;
      end
      return m;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic drive(vec_t v);
      req_addr     = v.addr;
      req_data     = v.val;
      req_span_end = v.span_end;
      req_dword    = v.dword;
      req_valid    = 1'b1;
   endtask

   task automatic check_beat(vec_t v);
      string tag;
      if (v.e_empty)      tag = "R6";
      else if (v.dword)   tag = v.span_end ? "R5" : "R4";
      else                tag = v.span_end ? "R3" : "R2";
      chk("R9 bus_valid", 64'(bus_valid), 64'd1);
      chk("R1 bus_addr", 64'(bus_addr), 64'(v.e_addr));
      chk({tag, " R7 bus_be"}, 64'(bus_be), 64'(v.e_be));
      chk({tag, " R7 bus_wdata"}, bus_wdata & lane_mask(bus_be),
          v.e_wd);
      chk("R6 bus_empty", 64'(bus_empty), 64'(v.e_empty));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      int base_beats;
      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 bus_valid in reset", 64'(bus_valid), 64'd0);
      chk("R11 req_ready in reset", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 bus_valid after reset", 64'(bus_valid), 64'd0);

      // table walk, bus always ready
      base_beats = beats;
      for (int n = 0; n < NV; n++) begin
         drive(VECS[n]);
         @(posedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         check_beat(VECS[n]);
      end
      @(negedge clk);
      chk("R8 one beat per request", 64'(beats - base_beats), 64'(NV));
      chk("R8 no beat when idle", 64'(bus_valid), 64'd0);

      // backpressure: A held, B waits
      base_beats = beats;
      bus_ready = 1'b0;
      drive(VECS[12]);
      @(posedge clk);
      @(negedge clk);
      drive(VECS[1]);
      chk("R10 req_ready low when stalled", 64'(req_ready), 64'd0);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk("R10 held bus_be", 64'(bus_be), 64'(VECS[12].e_be));
         chk("R10 held bus_wdata", bus_wdata & lane_mask(bus_be),
             VECS[12].e_wd);
      end
      bus_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check_beat(VECS[1]);
      @(negedge clk);
      chk("R8 two beats after stall", 64'(beats - base_beats), 64'd2);

      // reset while a beat is pending
      bus_ready = 1'b0;
      drive(VECS[9]);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11 reset drops beat", 64'(bus_valid), 64'd0);
      chk("R11 ready in reset", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      bus_ready = 1'b1;
      @(negedge clk);
      summary();
   end

endmodule